// File: doc/BRIEF.md
# Buffered I2C Byte-Count Sequencer

This block runs one I2C transfer at byte granularity, driven by a programmed byte count. A host first loads an 8-bit count register. Bits [6:0] give the number of bytes and bit 7 is the last-byte flag. The host then writes the control register to start. The control write carries two bits. `ctl_buffered` selects buffered mode (1) or single-byte mode (0). `ctl_receive` selects receive (1) or transmit (0). A byte shifter outside this block handles the wire-level work. It reports each completed byte with a one-cycle `byte_done` pulse. It takes the outgoing byte from `tx_byte`, delivers the incoming byte on `rx_byte`, and samples `ack_out` as the acknowledge decision for that byte. Bytes move through a buffer of 68 entries. The host reaches the buffer through its own port while the sequencer is idle.

The controller has three states: IDLE, BURST and SINGLE.
- **start_burst** (IDLE to BURST) is a control write in buffered mode with a count field from 1 to 68.
- **reject** (IDLE to IDLE) is a buffered-mode control write with a count field of 0 or above 68. It moves no bytes and raises the interrupt at once.
- **start_single** (IDLE to SINGLE) is a control write in single-byte mode. It moves exactly one byte through buffer entry 0 and ignores the count register.
- **finish** (BURST or SINGLE to IDLE) is the `byte_done` pulse of the final byte. It raises the interrupt.
- **hold** keeps BURST or SINGLE in place on any other cycle.

The interrupt stays high until the next control write. While a transfer runs, it ignores writes to the count register and to the control register.

Top module: `i2c_burst_seq`

## Requirements
- R1: After reset, `busy`, `irq`, `ack_out` and `cnt_rdata` are all 0.
- R2: In IDLE, a buffered control write with count field 0 or greater than 68 moves no bytes. `busy` stays 0, `irq` is 1 from the next cycle, and `cnt_rdata` keeps its value.
- R3: A buffered transfer with count field N from 1 to 68 sets `busy` the cycle after the control write and clears `irq`. In transmit, the k-th byte (k from 0) presents buffer entry k on `tx_byte`. After the N-th `byte_done`, `busy` falls and `irq` rises in the same cycle.
- R4: In buffered receive, the k-th received byte is stored in buffer entry k, and the host port reads it back after the transfer.
- R5: In buffered receive, `cnt_rdata[6:0]` equals the number of bytes stored so far, with bit 7 still holding the last-byte flag. In transmit, `cnt_rdata` keeps the programmed value.
- R6: In buffered receive with last-byte flag 1, `ack_out` is 0 for the final byte and 1 for every earlier byte.
- R7: In buffered receive with last-byte flag 0, `ack_out` is 1 for every byte, including the final one.
- R8: In transmit, `ack_out` is 0 throughout, and a last-byte flag of 1 leaves the transfer unchanged.
- R9: In single-byte mode, the count register is not checked and not changed. Even a count of 0 starts a one-byte transfer with no reject interrupt. A received byte lands in entry 0 with `ack_out` 1, and a transmitted byte comes from entry 0.
- R10: Once `irq` is set, it stays 1 until the next control write.
- R11: While `busy` is 1, count-register writes and control writes have no effect.
- R12: A count of 68 is accepted as a full transfer, and a count of 69 is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cnt_wr | input | 1 | Count register write strobe |
| cnt_wdata | input | 8 | Count register write data (bit 7 last-byte flag, [6:0] count) |
| cnt_rdata | output | 8 | Count register readback |
| ctl_wr | input | 1 | Control write strobe; starts or rejects a transfer |
| ctl_buffered | input | 1 | 1 buffered mode, 0 single-byte mode |
| ctl_receive | input | 1 | 1 receive, 0 transmit |
| buf_wr | input | 1 | Host buffer write strobe (honoured only when idle) |
| buf_addr | input | 7 | Host buffer address |
| buf_wdata | input | 8 | Host buffer write data |
| buf_rdata | output | 8 | Host buffer read data (combinational) |
| byte_done | input | 1 | Shifter pulse: one byte finished |
| rx_byte | input | 8 | Byte received by the shifter |
| tx_byte | output | 8 | Byte for the shifter to send |
| ack_out | output | 1 | Acknowledge decision for the current received byte |
| xfer_rx | output | 1 | Active transfer is a receive |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Completion or reject interrupt |

## Verification
The clash of interest is a count-register write in the same cycle as the final receive `byte_done`. In that cycle the progress update and the host write both target the count register. The bench provokes this by raising `cnt_wr` together with the last `byte_done`, and also midway through a transfer. A control write is issued alongside the first `byte_done`. The count must read back as the last-byte flag plus N, and the transfer must run to its end. The boundary counts 0, 68, 69 and 127 are driven as directed cases.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BURST  = 2'd1,
        ST_SINGLE = 2'd2
    } bseq_state_e;
endpackage

// File: rtl/bseq_buf.sv
module bseq_buf #(
    parameter int DEPTH = 68,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && ({1'b0, waddr} < LIMIT))
            mem[waddr] <= wdata;
    end

    always_comb begin
        rdata_a = ({1'b0, raddr_a} < LIMIT) ? mem[raddr_a] : '0;
        rdata_b = ({1'b0, raddr_b} < LIMIT) ? mem[raddr_b] : '0;
    end
endmodule

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
    import bseq_pkg::*;
#(
    parameter int DEPTH = 68,
    parameter int CW    = 7,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_wr,
    input  logic [CW:0]   cnt_wdata,
    input  logic          ctl_wr,
    input  logic          ctl_buffered,
    input  logic          ctl_receive,
    input  logic          byte_done,
    output logic [CW:0]   cnt_q,
    output logic [AW-1:0] ptr_q,
    output logic          busy,
    output logic          rx_q,
    output logic          irq_q,
    output logic          ack_out,
    output logic          store_en
);
    localparam logic [CW-1:0] LIM = CW'(DEPTH);

    bseq_state_e   state_q, state_d;
    logic [CW-1:0] target_q;
    logic          bad_cnt, start_burst, start_single, reject, last_byte, step;

    always_comb begin
        bad_cnt      = (cnt_q[CW-1:0] == '0) || (cnt_q[CW-1:0] > LIM);
        start_burst  = (state_q == ST_IDLE) && ctl_wr && ctl_buffered && !bad_cnt;
        start_single = (state_q == ST_IDLE) && ctl_wr && !ctl_buffered;
        reject       = (state_q == ST_IDLE) && ctl_wr && ctl_buffered && bad_cnt;
        last_byte    = ((CW'(ptr_q) + CW'(1)) == target_q);
        busy         = (state_q != ST_IDLE);
        step         = busy && byte_done;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_burst)       state_d = ST_BURST;
                else if (start_single) state_d = ST_SINGLE;
            end
            ST_BURST, ST_SINGLE: begin
                if (byte_done && last_byte) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            target_q <= '0;
            ptr_q    <= '0;
            rx_q     <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            if (cnt_wr && !busy)
                cnt_q <= cnt_wdata;
            if (!busy && ctl_wr) begin
                irq_q <= reject;
                rx_q  <= ctl_receive;
                ptr_q <= '0;
                if (start_burst) begin
                    target_q <= cnt_q[CW-1:0];
                    if (ctl_receive) cnt_q[CW-1:0] <= '0;
                end
                if (start_single) target_q <= CW'(1);
            end
            if (step) begin
                ptr_q <= ptr_q + AW'(1);
                if (rx_q && (state_q == ST_BURST))
                    cnt_q[CW-1:0] <= cnt_q[CW-1:0] + CW'(1);
                if (last_byte) irq_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        ack_out  = rx_q && busy &&
                   !((state_q == ST_BURST) && last_byte && cnt_q[CW]);
        store_en = step && rx_q;
    end

    p_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> (state_q == ST_IDLE) && irq_q);

    p_quiet_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !irq_q);

    p_ptr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BURST) |-> (CW'(ptr_q) < target_q));

    p_nack_final_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && rx_q && !ack_out) |=> (state_q == ST_IDLE));

    p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !ctl_wr) |=> irq_q);

    p_cnt_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !byte_done) |=> $stable(cnt_q));
endmodule

// File: rtl/i2c_burst_seq.sv
module i2c_burst_seq #(
    parameter int DEPTH = 68,
    parameter int CW    = 7,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_wr,
    input  logic [CW:0]   cnt_wdata,
    output logic [CW:0]   cnt_rdata,
    input  logic          ctl_wr,
    input  logic          ctl_buffered,
    input  logic          ctl_receive,
    input  logic          buf_wr,
    input  logic [AW-1:0] buf_addr,
    input  logic [DW-1:0] buf_wdata,
    output logic [DW-1:0] buf_rdata,
    input  logic          byte_done,
    input  logic [DW-1:0] rx_byte,
    output logic [DW-1:0] tx_byte,
    output logic          ack_out,
    output logic          xfer_rx,
    output logic          busy,
    output logic          irq
);
    logic [AW-1:0] ptr;
    logic          rx_mode, store_en;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [DW-1:0] mem_wdata;

    bseq_ctrl #(.DEPTH(DEPTH), .CW(CW), .AW(AW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cnt_wr       (cnt_wr),
        .cnt_wdata    (cnt_wdata),
        .ctl_wr       (ctl_wr),
        .ctl_buffered (ctl_buffered),
        .ctl_receive  (ctl_receive),
        .byte_done    (byte_done),
        .cnt_q        (cnt_rdata),
        .ptr_q        (ptr),
        .busy         (busy),
        .rx_q         (rx_mode),
        .irq_q        (irq),
        .ack_out      (ack_out),
        .store_en     (store_en)
    );

    always_comb begin
        mem_we    = busy ? store_en : buf_wr;
        mem_waddr = busy ? ptr      : buf_addr;
        mem_wdata = busy ? rx_byte  : buf_wdata;
        xfer_rx   = busy && rx_mode;
    end

    bseq_buf #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_buf (
        .clk     (clk),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wdata   (mem_wdata),
        .raddr_a (ptr),
        .rdata_a (tx_byte),
        .raddr_b (buf_addr),
        .rdata_b (buf_rdata)
    );
endmodule

// File: tb/i2c_burst_seq_test.sv
module i2c_burst_seq_test;
    localparam int DEPTH = 68;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cnt_wr, ctl_wr, ctl_buffered, ctl_receive, buf_wr, byte_done;
    logic [7:0] cnt_wdata, cnt_rdata, buf_wdata, buf_rdata, rx_byte, tx_byte;
    logic [6:0] buf_addr;
    logic       ack_out, xfer_rx, busy, irq;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  finished = 0;
    logic [7:0] model [DEPTH];

    always #5 clk = ~clk;

    i2c_burst_seq uut (
        .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .cnt_rdata(cnt_rdata), .ctl_wr(ctl_wr), .ctl_buffered(ctl_buffered),
        .ctl_receive(ctl_receive), .buf_wr(buf_wr), .buf_addr(buf_addr),
        .buf_wdata(buf_wdata), .buf_rdata(buf_rdata), .byte_done(byte_done),
        .rx_byte(rx_byte), .tx_byte(tx_byte), .ack_out(ack_out),
        .xfer_rx(xfer_rx), .busy(busy), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_ack(input bit rx, input bit lb, input int k, input int n);
        if (!rx) return 1'b0;
        return !((k == n - 1) && lb);
    endfunction

    task automatic host_load(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            buf_wr    = 1'b1;
            buf_addr  = 7'(i);
            buf_wdata = 8'($urandom);
            model[i]  = buf_wdata;
        end
        @(negedge clk);
        buf_wr = 1'b0;
    endtask

    task automatic set_count(input logic [7:0] v);
        @(negedge clk);
        cnt_wr = 1'b1; cnt_wdata = v;
        @(negedge clk);
        cnt_wr = 1'b0;
    endtask

    task automatic ctl(input bit buffered, input bit rx);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_buffered = buffered; ctl_receive = rx;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic run_xfer(input int n, input bit rx, input bit lb, input bit poke);
        logic [7:0] d;
        if (!rx) host_load(n);
        set_count({lb, 7'(n)});
        ctl(1'b1, rx);
        chk(busy == 1'b1, "R3 busy after start", busy, 1);
        chk(irq == 1'b0, "R10 irq cleared by control write", irq, 0);
        for (int k = 0; k < n; k++) begin
            repeat ($urandom % 3) @(negedge clk);
            if (!rx) chk(tx_byte == model[k], "R3 tx_byte", tx_byte, model[k]);
            chk(ack_out == exp_ack(rx, lb, k, n),
                rx ? (lb ? "R6 ack" : "R7 ack") : "R8 ack in transmit",
                ack_out, exp_ack(rx, lb, k, n));
            d = 8'($urandom);
            byte_done = 1'b1; rx_byte = d;
            if (rx) model[k] = d;
            if (poke && (k == n - 1 || k == n / 2)) begin
                cnt_wr = 1'b1; cnt_wdata = 8'h03;
            end
            if (poke && k == 0) begin
                ctl_wr = 1'b1; ctl_buffered = 1'b1; ctl_receive = !rx;
            end
            @(negedge clk);
            byte_done = 1'b0; cnt_wr = 1'b0; ctl_wr = 1'b0;
            if (rx) chk(cnt_rdata == {lb, 7'(k + 1)}, "R5 stored count", cnt_rdata, {lb, 7'(k + 1)});
            if (k < n - 1) chk(busy == 1'b1, "R11 transfer keeps running", busy, 1);
        end
        chk(busy == 1'b0, "R3 busy falls after last byte", busy, 0);
        chk(irq == 1'b1, "R3 irq on completion", irq, 1);
        chk(cnt_rdata == {lb, 7'(n)}, "R11 R5 count after transfer", cnt_rdata, {lb, 7'(n)});
        if (rx) begin
            for (int i = 0; i < n; i++) begin
                buf_addr = 7'(i);
                #1;
                chk(buf_rdata == model[i], "R4 stored byte", buf_rdata, model[i]);
            end
        end
        repeat (3) @(negedge clk);
        chk(irq == 1'b1, "R10 irq held", irq, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; cnt_wr = 0; ctl_wr = 0; ctl_buffered = 0; ctl_receive = 0;
        buf_wr = 0; byte_done = 0; cnt_wdata = 0; buf_wdata = 0; buf_addr = 0; rx_byte = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0, "R1 busy", busy, 0);
        chk(irq == 0, "R1 irq", irq, 0);
        chk(ack_out == 0, "R1 ack_out", ack_out, 0);
        chk(cnt_rdata == 0, "R1 count", cnt_rdata, 0);

        // R2: zero count rejected
        set_count(8'h00);
        ctl(1'b1, 1'b0);
        chk(busy == 0, "R2 zero count no start", busy, 0);
        chk(irq == 1, "R2 zero count irq", irq, 1);
        chk(cnt_rdata == 8'h00, "R2 count kept", cnt_rdata, 0);

        // R12: 69 rejected
        set_count(8'd69);
        ctl(1'b1, 1'b1);
        chk(busy == 0, "R12 count 69 no start", busy, 0);
        chk(irq == 1, "R12 count 69 irq", irq, 1);
        chk(cnt_rdata == 8'd69, "R12 count 69 kept", cnt_rdata, 69);

        // R2: 127 with flag rejected
        set_count(8'hFF);
        ctl(1'b1, 1'b1);
        chk(busy == 0, "R2 count 127 no start", busy, 0);
        chk(irq == 1, "R2 count 127 irq", irq, 1);
        chk(ack_out == 0, "R2 no ack when idle", ack_out, 0);

        // R12: full 68-byte transfers
        run_xfer(68, 1'b1, 1'b1, 1'b0);
        run_xfer(68, 1'b0, 1'b1, 1'b0);
        // single-byte receive with final NACK (R6)
        run_xfer(1, 1'b1, 1'b1, 1'b0);
        // same-cycle count writes and control writes while busy (R11)
        run_xfer(5, 1'b1, 1'b0, 1'b1);
        run_xfer(4, 1'b0, 1'b0, 1'b1);

        // R9: single-byte mode receive with count 0
        set_count(8'h00);
        ctl(1'b0, 1'b1);
        chk(busy == 1, "R9 single starts despite zero count", busy, 1);
        chk(irq == 0, "R9 no reject irq", irq, 0);
        chk(ack_out == 1, "R9 single receive ack", ack_out, 1);
        byte_done = 1'b1; rx_byte = 8'h5A;
        @(negedge clk);
        byte_done = 1'b0;
        chk(busy == 0, "R9 single done", busy, 0);
        chk(irq == 1, "R9 single irq", irq, 1);
        chk(cnt_rdata == 8'h00, "R9 count untouched", cnt_rdata, 0);
        buf_addr = 7'd0;
        #1;
        chk(buf_rdata == 8'h5A, "R9 entry 0 stored", buf_rdata, 8'h5A);

        // R9: single-byte transmit with a large count
        set_count(8'h85);
        host_load(1);
        ctl(1'b0, 1'b0);
        chk(busy == 1, "R9 single tx start", busy, 1);
        chk(tx_byte == model[0], "R9 single tx byte", tx_byte, model[0]);
        chk(ack_out == 0, "R9 single tx no ack", ack_out, 0);
        byte_done = 1'b1;
        @(negedge clk);
        byte_done = 1'b0;
        chk(busy == 0, "R9 single tx done", busy, 0);
        chk(cnt_rdata == 8'h85, "R9 count untouched tx", cnt_rdata, 8'h85);

        // constrained random transfers
        for (int it = 0; it < 16; it++) begin
            run_xfer(1 + int'($urandom % 68), 1'($urandom), 1'($urandom),
                     ($urandom % 4) == 0);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule